// File: doc/BRIEF.md
# Strobe-Clocked Burst Write Capture

This block is the memory-side write path of a double-data-rate SDRAM. A write command with a column address is taken on the rising edge of the main clock. The block then collects a burst of data elements from a separate data strobe. Rising strobe edges and falling strobe edges each deliver one element, so two elements arrive per strobe cycle. Every element carries one mask bit per byte. The bytes that are not masked go into a small word array at the columns of the burst, which count up from the start column and wrap inside the aligned block of one burst length.

Strobe-domain flops land the elements in a two-deep ping-pong set of slots. The clock domain moves each rise/fall pair into a burst buffer one clock after the pair arrives, then writes the whole burst into the array in a single commit cycle. On falling clock edges the block checks the strobe. It must be low, with no rising edge yet, half a cycle after the command. Exactly one rising edge must have arrived one and a half cycles after the command. Any violation raises a sticky error flag. A combinational peek port reads one array word, so the stored contents can be observed.

Top module: `sc_strobe_write`

## Requirements
- R1: A command (`wr_cmd` high at a rising clock edge) is accepted when no burst is active or in the commit cycle; a command arriving while a burst is still collecting is ignored and does not change the target columns.
- R2: Element k of a burst (k = 0 .. BL-1) comes from the k-th strobe edge after the command: even k on rising edges, odd k on falling edges. It is stored at column (S & ~(BL-1)) | ((S + k) mod BL), where S is the start column.
- R3: Each element has `dm` bits sampled with its data. `dm[0]` = 0 writes `dq[7:0]` and `dm[0]` = 1 leaves that byte unchanged. `dm[1]` does the same for `dq[15:8]`.
- R4: The array changes only at the rising clock edge BL/2+2 edges after the accepting edge (edge T+4 for BL = 4). Before that edge the target words still hold their old values.
- R5: `win_err` is set if, at the falling clock edge half a cycle after the accepting edge, the strobe is high or a rising strobe edge has already been seen (preamble violation or early first edge).
- R6: `win_err` is set if, at the falling clock edge one and a half cycles after the accepting edge, the number of rising strobe edges seen since the command is not exactly one (late first edge or edges too close together).
- R7: `win_err` stays high until reset. A synchronous reset clears `win_err` and the burst state, and it leaves the array contents unchanged.
- R8: Strobe edges and data while no burst is collecting are ignored: the array is unchanged and later bursts are captured correctly.
- R9: A new command accepted in the commit cycle of the previous burst starts a new burst, and both bursts land correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main command clock |
| rst | input | 1 | Synchronous active-high reset (also clears strobe-domain capture) |
| wr_cmd | input | 1 | Write command, sampled on rising clock edges |
| wr_col | input | CW | Start column of the burst |
| dqs | input | 1 | Data strobe; both edges capture data |
| dq | input | DW | Write data element |
| dm | input | DW/8 | Per-byte mask, high means keep old byte |
| peek_col | input | CW | Column to observe |
| peek_data | output | DW | Array word at `peek_col` |
| win_err | output | 1 | Sticky strobe window / preamble error |

## Verification
The commit of one burst and the acceptance of the next command can fall on the same rising clock edge. The bench starts a second command so that it is accepted exactly BL/2+2 edges after the first. It then checks that the first burst's words, the second burst's words and the error flag are all correct once both commits are done. A second overlap is a command that arrives while a burst is still collecting. That command must be dropped, and the bench checks this by finding the columns it named unchanged.

// File: rtl/sc_pkg.sv
package sc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BURST  = 2'd1,
    ST_COMMIT = 2'd2
  } wr_state_e;

  // Ping-pong slot holding pair number 'pair' when the burst began at 'base'.
  function automatic logic pp_slot(input logic base, input int pair);
    return base ^ pair[0];
  endfunction

endpackage

// File: rtl/sc_dqs_capture.sv
module sc_dqs_capture #(
  parameter int EW = 18
) (
  input  logic                rst,
  input  logic                dqs,
  input  logic                cap_en,
  input  logic [EW-1:0]       elem_in,
  output logic                rise_ptr,
  output logic                fall_ptr,
  output logic [1:0][EW-1:0]  rise_slot,
  output logic [1:0][EW-1:0]  fall_slot
);

  // Even elements: rising strobe edges.
  always_ff @(posedge dqs or posedge rst) begin
    if (rst) begin
      rise_ptr  <= 1'b0;
      rise_slot <= '0;
    end else if (cap_en) begin
      rise_slot[rise_ptr] <= elem_in;
      rise_ptr            <= ~rise_ptr;
    end
  end

  // Odd elements: falling strobe edges.
  always_ff @(negedge dqs or posedge rst) begin
    if (rst) begin
      fall_ptr  <= 1'b0;
      fall_slot <= '0;
    end else if (cap_en) begin
      fall_slot[fall_ptr] <= elem_in;
      fall_ptr            <= ~fall_ptr;
    end
  end

endmodule

// File: rtl/sc_window_check.sv
module sc_window_check (
  input  logic clk,
  input  logic rst,
  input  logic dqs,
  input  logic rise_ptr,
  input  logic base_rise,
  input  logic chk_pre,
  input  logic chk_first,
  output logic win_err
);

  // Named events for the assertions.
  logic pre_bad;
  logic first_bad;

  assign pre_bad   = chk_pre   && (dqs || (rise_ptr != base_rise));
  assign first_bad = chk_first && (rise_ptr == base_rise);

  always_ff @(negedge clk) begin
    if (rst)
      win_err <= 1'b0;
    else if (pre_bad || first_bad)
      win_err <= 1'b1;
  end

  // R7: once raised, the flag holds until reset
  assert_err_sticky_R7: assert property (@(negedge clk) disable iff (rst)
    win_err |=> win_err);

  // R5: a high strobe in the preamble slot always ends in the flag
  assert_preamble_high_R5: assert property (@(negedge clk) disable iff (rst)
    (chk_pre && dqs) |=> win_err);

endmodule

// File: rtl/sc_word_array.sv
module sc_word_array #(
  parameter  int COLS = 16,
  parameter  int DW   = 16,
  parameter  int BL   = 4,
  localparam int CW   = $clog2(COLS),
  localparam int MW   = DW / 8,
  localparam int EW   = DW + MW
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  we,
  input  logic [BL-1:0][CW-1:0] cols,
  input  logic [BL-1:0][EW-1:0] elems,
  input  logic [CW-1:0]         peek_col,
  output logic [DW-1:0]         peek_data
);

  logic [DW-1:0] mem [COLS];

  for (genvar w = 0; w < COLS; w++) begin : g_word
    for (genvar b = 0; b < MW; b++) begin : g_byte
      logic       hit;
      logic [7:0] val;

      always_comb begin
        hit = 1'b0;
        val = '0;
        for (int k = 0; k < BL; k++) begin
          if (we && (cols[k] == CW'(w)) && !elems[k][DW+b]) begin
            hit = 1'b1;
            val = elems[k][b*8 +: 8];
          end
        end
      end

      always_ff @(posedge clk) begin
        if (hit) mem[w][b*8 +: 8] <= val;
      end

      // R4: a stored byte moves only on the edge after a commit request
      assert_write_only_on_commit_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(mem[w][b*8 +: 8]) |-> $past(we));
    end
  end

  assign peek_data = mem[peek_col];

endmodule

// File: rtl/sc_strobe_write.sv
module sc_strobe_write #(
  parameter  int BL   = 4,
  parameter  int COLS = 16,
  parameter  int DW   = 16,
  localparam int NP   = BL / 2,
  localparam int LB   = $clog2(BL),
  localparam int CW   = $clog2(COLS),
  localparam int MW   = DW / 8,
  localparam int EW   = DW + MW,
  localparam int CNTW = $clog2(NP + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_cmd,
  input  logic [CW-1:0] wr_col,
  input  logic          dqs,
  input  logic [DW-1:0] dq,
  input  logic [MW-1:0] dm,
  input  logic [CW-1:0] peek_col,
  output logic [DW-1:0] peek_data,
  output logic          win_err
);
  import sc_pkg::*;

  // Column of element k: count up inside the aligned burst block.
  function automatic logic [CW-1:0] burst_col(input logic [CW-1:0] start, input int k);
    logic [LB-1:0] off;
    off = start[LB-1:0] + LB'(k);
    return {start[CW-1:LB], off};
  endfunction

  wr_state_e             st;
  logic [CNTW-1:0]       cnt;
  logic [CW-1:0]         start_col;
  logic                  base_r, base_f;
  logic                  cap_en;
  logic [BL-1:0][EW-1:0] burst_buf;

  logic                  rise_ptr, fall_ptr;
  logic [1:0][EW-1:0]    rise_slot, fall_slot;

  // Named events.
  logic accept, collecting, commit, chk_pre, chk_first;
  assign collecting = (st == ST_BURST);
  assign commit     = (st == ST_COMMIT);
  assign accept     = wr_cmd && (st == ST_IDLE || commit);
  assign chk_pre    = collecting && (cnt == '0);
  assign chk_first  = collecting && (cnt == CNTW'(1));

  sc_dqs_capture #(.EW(EW)) u_cap (
    .rst      (rst),
    .dqs      (dqs),
    .cap_en   (cap_en),
    .elem_in  ({dm, dq}),
    .rise_ptr (rise_ptr),
    .fall_ptr (fall_ptr),
    .rise_slot(rise_slot),
    .fall_slot(fall_slot)
  );

  sc_window_check u_win (
    .clk      (clk),
    .rst      (rst),
    .dqs      (dqs),
    .rise_ptr (rise_ptr),
    .base_rise(base_r),
    .chk_pre  (chk_pre),
    .chk_first(chk_first),
    .win_err  (win_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      start_col <= '0;
      base_r    <= 1'b0;
      base_f    <= 1'b0;
      cap_en    <= 1'b0;
      burst_buf <= '0;
    end else if (accept) begin
      st        <= ST_BURST;
      cnt       <= '0;
      start_col <= wr_col;
      base_r    <= rise_ptr;
      base_f    <= fall_ptr;
      cap_en    <= 1'b1;
    end else begin
      case (st)
        ST_BURST: begin
          cnt <= cnt + 1'b1;
          for (int j = 0; j < NP; j++) begin
            if (cnt == CNTW'(j + 1)) begin
              burst_buf[2*j]   <= rise_slot[pp_slot(base_r, j)];
              burst_buf[2*j+1] <= fall_slot[pp_slot(base_f, j)];
            end
          end
          if (cnt == CNTW'(NP)) begin
            st     <= ST_COMMIT;
            cap_en <= 1'b0;
          end
        end
        ST_COMMIT: st <= ST_IDLE;
        default:   st <= ST_IDLE;
      endcase
    end
  end

  logic [BL-1:0][CW-1:0] elem_cols;
  always_comb begin
    for (int k = 0; k < BL; k++) elem_cols[k] = burst_col(start_col, k);
  end

  sc_word_array #(.COLS(COLS), .DW(DW), .BL(BL)) u_arr (
    .clk      (clk),
    .rst      (rst),
    .we       (commit),
    .cols     (elem_cols),
    .elems    (burst_buf),
    .peek_col (peek_col),
    .peek_data(peek_data)
  );

  // R1: a command during collection leaves the target untouched
  assert_busy_cmd_ignored_R1: assert property (@(posedge clk) disable iff (rst)
    (wr_cmd && collecting) |=> $stable(start_col));

  // R4: commit lasts exactly one cycle
  assert_single_commit_R4: assert property (@(posedge clk) disable iff (rst)
    commit |=> !commit);

  // R8: strobe capture is closed whenever no burst is running
  assert_capture_closed_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE) |-> !cap_en);

endmodule

// File: tb/tb_sc_strobe_write.sv
`timescale 1ns/100ps
module tb_sc_strobe_write;
  localparam int BL   = 4;
  localparam int COLS = 16;
  localparam int DW   = 16;

  typedef struct packed {
    logic [3:0]        col;
    logic [3:0][15:0]  data;
    logic [3:0][1:0]   dm;
    logic [15:0]       dd;   // first rising strobe, tenths of ns after command edge
    logic              err;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{col: 4'd0,  data: {16'h3333, 16'h2222, 16'h1111, 16'h0A0A}, dm: {2'b00, 2'b00, 2'b00, 2'b00}, dd: 16'd100, err: 1'b0},
    '{col: 4'd6,  data: {16'hD4D4, 16'hC3C3, 16'hB2B2, 16'hA1A1}, dm: {2'b11, 2'b10, 2'b01, 2'b00}, dd: 16'd75,  err: 1'b0},
    '{col: 4'd13, data: {16'h5E5E, 16'h4D4D, 16'h3C3C, 16'h2B2B}, dm: {2'b00, 2'b00, 2'b00, 2'b00}, dd: 16'd125, err: 1'b0},
    '{col: 4'd2,  data: {16'hFFFF, 16'hEEEE, 16'hDDDD, 16'hCCCC}, dm: {2'b11, 2'b11, 2'b11, 2'b11}, dd: 16'd30,  err: 1'b1},
    '{col: 4'd9,  data: {16'h9999, 16'h8888, 16'h7777, 16'h6666}, dm: {2'b11, 2'b11, 2'b11, 2'b11}, dd: 16'd170, err: 1'b1},
    '{col: 4'd15, data: {16'h7171, 16'h6161, 16'h5151, 16'h4141}, dm: {2'b00, 2'b01, 2'b00, 2'b10}, dd: 16'd100, err: 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_cmd = 1'b0;
  logic [3:0]    wr_col = '0;
  logic          dqs = 1'b0;
  logic [15:0]   dq = '0;
  logic [1:0]    dm = '0;
  logic [3:0]    peek_col = '0;
  logic [15:0]   peek_data;
  logic          win_err;

  int total = 0;
  int bad   = 0;
  logic [15:0] model [COLS];

  always #5 clk = ~clk;

  sc_strobe_write #(.BL(BL), .COLS(COLS), .DW(DW)) dut (
    .clk(clk), .rst(rst), .wr_cmd(wr_cmd), .wr_col(wr_col), .dqs(dqs),
    .dq(dq), .dm(dm), .peek_col(peek_col), .peek_data(peek_data), .win_err(win_err)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int bcol(input int c, input int k);
    return (c / BL) * BL + ((c + k) % BL);
  endfunction

  task automatic model_write(input logic [3:0] c, input logic [3:0][15:0] d, input logic [3:0][1:0] m);
    for (int k = 0; k < BL; k++) begin
      int a;
      a = bcol(int'(c), k);
      if (!m[k][0]) model[a][7:0]  = d[k][7:0];
      if (!m[k][1]) model[a][15:8] = d[k][15:8];
    end
  endtask

  task automatic check_all(input string req);
    for (int c = 0; c < COLS; c++) begin
      peek_col = 4'(c);
      #0.1;
      chk(req, {16'h0, peek_data}, {16'h0, model[c]});
    end
  endtask

  task automatic send_cmd(input logic [3:0] c);
    @(negedge clk);
    wr_cmd = 1'b1;
    wr_col = c;
    @(posedge clk);
    #1 wr_cmd = 1'b0;
  endtask

  // Starts 1 ns after the accepting edge.
  task automatic drive_burst(input logic [3:0][15:0] d, input logic [3:0][1:0] m, input logic [15:0] dd);
    #(real'(dd) / 10.0 - 3.0);
    dq = d[0];
    dm = m[0];
    #2 dqs = 1'b1;
    for (int k = 1; k < BL; k++) begin
      #3 dq = d[k];
      dm = m[k];
      #2 dqs = ~dqs;
    end
    #3 dq = '0;
    dm = '0;
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk) rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    chk("R7 reset clears err", {31'h0, win_err}, 32'h0);
    for (int c = 0; c < COLS; c++) begin
      peek_col = 4'(c);
      #0.1 model[c] = peek_data;
    end

    // Vector table: R2 order/wrap, R3 masks, R4 timing, R5/R6 window.
    for (int i = 0; i < 6; i++) begin
      vec_t v;
      v = VECS[i];
      send_cmd(v.col);
      fork
        drive_burst(v.data, v.dm, v.dd);
        begin
          repeat (3) @(posedge clk);
          @(negedge clk);
          peek_col = v.col;
          #0.1 chk("R4 old value before commit", {16'h0, peek_data}, {16'h0, model[v.col]});
          @(posedge clk);
          @(negedge clk);
        end
      join
      model_write(v.col, v.data, v.dm);
      check_all("R2 R3 R4 array after commit");
      chk(v.err ? "R5 R6 window error set" : "R5 R6 window clean", {31'h0, win_err}, {31'h0, v.err});
      if (v.err) begin
        do_reset();
        chk("R7 reset clears err", {31'h0, win_err}, 32'h0);
        check_all("R7 array kept over reset");
      end
    end

    // R7: flag stays up across idle cycles until reset
    send_cmd(4'd3);
    drive_burst({16'h1, 16'h2, 16'h3, 16'h4}, {2'b11, 2'b11, 2'b11, 2'b11}, 16'd30);
    repeat (6) @(posedge clk);
    @(negedge clk);
    chk("R7 err sticky", {31'h0, win_err}, 32'h1);
    do_reset();
    chk("R7 err cleared", {31'h0, win_err}, 32'h0);

    // R8: strobe activity with no command
    repeat (2) @(negedge clk);
    dq = 16'hDEAD;
    dm = 2'b00;
    for (int k = 0; k < 6; k++) #3 dqs = ~dqs;
    dqs = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R8 idle edges ignored");
    send_cmd(4'd10);
    drive_burst({16'hA003, 16'hA002, 16'hA001, 16'hA000}, '0, 16'd100);
    repeat (4) @(posedge clk);
    @(negedge clk);
    model_write(4'd10, {16'hA003, 16'hA002, 16'hA001, 16'hA000}, '0);
    check_all("R8 burst after idle edges");
    chk("R8 no error", {31'h0, win_err}, 32'h0);

    // R1: command while collecting is ignored
    send_cmd(4'd4);
    fork
      drive_burst({16'hB103, 16'hB102, 16'hB101, 16'hB100}, '0, 16'd100);
      send_cmd(4'd8);
    join
    repeat (5) @(posedge clk);
    @(negedge clk);
    model_write(4'd4, {16'hB103, 16'hB102, 16'hB101, 16'hB100}, '0);
    check_all("R1 busy command dropped");

    // R9: next command accepted in the commit cycle
    send_cmd(4'd0);
    fork
      drive_burst({16'hC003, 16'hC002, 16'hC001, 16'hC000}, '0, 16'd100);
      begin
        repeat (3) @(posedge clk);
        send_cmd(4'd9);
        drive_burst({16'hC903, 16'hC902, 16'hC901, 16'hC900}, {2'b00, 2'b01, 2'b10, 2'b00}, 16'd100);
      end
    join
    repeat (6) @(posedge clk);
    @(negedge clk);
    model_write(4'd0, {16'hC003, 16'hC002, 16'hC001, 16'hC000}, '0);
    model_write(4'd9, {16'hC903, 16'hC902, 16'hC901, 16'hC900}, {2'b00, 2'b01, 2'b10, 2'b00});
    check_all("R9 back-to-back bursts");
    chk("R9 no error", {31'h0, win_err}, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule